// File: doc/BRIEF.md
# Transmit FIFO Start and Refill Gate

This block sits beside a MAC transmit FIFO and decides three things each clock: whether the FIFO has enough free room to ask the host-side bus master for more data; whether the frame now loading may begin on the wire; and how far the read side may hand bytes back for overwrite. It does not store data itself. It watches the FIFO occupancy, the byte counts of the current frame on the write and the wire sides, and the collision, completion and discard events. From these it drives a refill request, a start pulse, a rewind pulse and a release pointer.

A frame may start once a programmable number of its bytes are in the FIFO, or earlier if the whole frame is already loaded. Until the first 64 bytes of an attempt, counted with the preamble, have left without a collision, the release pointer stays at the frame's first byte. An early collision can then rewind the read side and retry from the FIFO without a reload. When either restart mode is enabled, the whole frame is kept until it completes or is discarded, and a retry after a collision waits for the full frame to be loaded.

Top module: `txf_gate`

## Requirements
- R1: `bus_req` is 1 in the cycle after a clock edge at which the free space (`DEPTH - fifo_level`) was at least the watermark, and 0 otherwise. `cfg_wmark` encodes the watermark: 00 = 16, 01 = 64, 10 = 128, 11 = 256 bytes.
- R2: While waiting, with no retry pending and no backoff, `tx_start` is raised when `frame_bytes` is at least the start threshold. `cfg_start` encodes the threshold: 00 = 16, 01 = 64, 10 = 128, 11 = 256 bytes.
- R3: While waiting, with no retry pending and no backoff, `frame_loaded` = 1 raises `tx_start` even when `frame_bytes` is below the threshold.
- R4: `tx_start` is a one-cycle registered pulse, given once per attempt. No pulse follows a clock edge at which `backoff_busy` was 1.
- R5: `coll_retry` during an attempt gives a one-cycle `rewind` pulse in the next cycle and returns the block to waiting, so that a later `tx_start` begins a new attempt.
- R6: With both restart modes off, `release_ptr` does not move during an attempt while `tx_bytes` < 64. From an edge where `tx_bytes` ≥ 64 it takes the value of `rd_ptr`.
- R7: With `cfg_rex_retry` or `cfg_rex_uflo` set, `release_ptr` does not move during an attempt whatever `tx_bytes` is.
- R8: A `tx_done` or `tx_drop` pulse loads `frame_end` into `release_ptr` and returns the block to waiting.
- R9: After a collision with a restart mode on, the next `tx_start` waits for `frame_loaded`, even when `frame_bytes` is at or above the threshold.
- R10: While `rst_n` is 0, `bus_req`, `tx_start` and `rewind` are 0, `release_ptr` is 0, and the block is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LVL_W | Bytes held in the FIFO |
| frame_bytes | input | CNT_W | Bytes of the current frame written so far |
| frame_loaded | input | 1 | End of the current frame is in the FIFO |
| tx_bytes | input | CNT_W | Bytes sent in this attempt, preamble included |
| rd_ptr | input | PTR_W | Read-side pointer of the serializer |
| frame_end | input | PTR_W | Pointer just past the current frame |
| backoff_busy | input | 1 | Backoff interval running |
| coll_retry | input | 1 | Retryable collision pulse |
| tx_done | input | 1 | Frame fully sent pulse |
| tx_drop | input | 1 | Frame discarded pulse |
| cfg_wmark | input | 2 | Refill watermark code |
| cfg_start | input | 2 | Start threshold code |
| cfg_rex_retry | input | 1 | Restart on excessive collisions enabled |
| cfg_rex_uflo | input | 1 | Restart on underflow enabled |
| bus_req | output | 1 | Refill request to the bus master |
| tx_start | output | 1 | Start pulse for one attempt |
| rewind | output | 1 | Rewind read side to the frame's first byte |
| release_ptr | output | PTR_W | Bytes before this pointer may be overwritten |

## Verification
A wrong wait/send state shows within one clock: either a `tx_start` appears that the model did not expect, or a `rewind` that should have followed a collision is missing. A stale retry-pending flag shows at the next start decision as a start that comes too early or too late relative to `frame_loaded`. A wrong commit decision moves `release_ptr` one cycle after the edge where `tx_bytes` crosses 64. The reference model is compared with all four outputs on every clock, so each fault is reported in the cycle it first reaches a port.

// File: rtl/txf_pkg.sv
package txf_pkg;

   typedef enum logic {
      ST_WAIT = 1'b0,
      ST_SEND = 1'b1
   } txf_state_e;

   // Byte count selected by a 2-bit threshold code (watermark and start point)
   function automatic int unsigned thr_bytes(input logic [1:0] code);
      case (code)
         2'b00:   return 16;
         2'b01:   return 64;
         2'b10:   return 128;
         default: return 256;
      endcase
   endfunction

endpackage

// File: rtl/txf_refill.sv
module txf_refill #(
   parameter int DEPTH   = 512,
   parameter int LVL_W   = $clog2(DEPTH + 1),
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [1:0]       cfg_wmark,
   output logic             bus_req
);

   logic [LVL_W-1:0] free_w;
   logic [LVL_W-1:0] thr_w;
   logic             want;

   assign free_w = LVL_W'(DEPTH) - fifo_level;
   assign thr_w  = LVL_W'(txf_pkg::thr_bytes(cfg_wmark));
   assign want   = (free_w >= thr_w);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) bus_req <= 1'b0;
            else        bus_req <= want;
         end
      end else begin : g_comb
         assign bus_req = want && rst_n;
      end
   endgenerate

endmodule

// File: rtl/txf_start.sv
module txf_start #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] frame_bytes,
   input  logic             frame_loaded,
   input  logic             backoff_busy,
   input  logic             coll_retry,
   input  logic             end_evt,
   input  logic [1:0]       cfg_start,
   input  logic             retain,
   output logic             tx_start,
   output logic             rewind,
   output logic             sending
);
   import txf_pkg::*;

   txf_state_e       st;
   logic             pend;
   logic [CNT_W-1:0] thr_w;
   logic             start_ok;

   assign thr_w = CNT_W'(thr_bytes(cfg_start));

   always_comb begin
      if (pend) start_ok = frame_loaded;
      else      start_ok = frame_loaded || (frame_bytes >= thr_w);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_WAIT;
         pend     <= 1'b0;
         tx_start <= 1'b0;
         rewind   <= 1'b0;
      end else begin
         tx_start <= 1'b0;
         rewind   <= 1'b0;
         if (end_evt) begin
            st   <= ST_WAIT;
            pend <= 1'b0;
         end else begin
            case (st)
               ST_WAIT: begin
                  if (start_ok && !backoff_busy) begin
                     tx_start <= 1'b1;
                     st       <= ST_SEND;
                     pend     <= 1'b0;
                  end
               end
               default: begin
                  if (coll_retry) begin
                     rewind <= 1'b1;
                     st     <= ST_WAIT;
                     pend   <= retain;
                  end
               end
            endcase
         end
      end
   end

   assign sending = (st == ST_SEND);

   // R4
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);
   // R4
   backoff_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> $past(!backoff_busy));
   // R5
   rewind_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rewind |=> !rewind);
   // R3
   loaded_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !pend && frame_loaded && !backoff_busy && !end_evt) |=> tx_start);

endmodule

// File: rtl/txf_release.sv
module txf_release #(
   parameter int CNT_W       = 16,
   parameter int PTR_W       = 9,
   parameter int COMMIT_BYTES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sending,
   input  logic             retain,
   input  logic [CNT_W-1:0] tx_bytes,
   input  logic [PTR_W-1:0] rd_ptr,
   input  logic [PTR_W-1:0] frame_end,
   input  logic             end_evt,
   output logic [PTR_W-1:0] release_ptr
);

   localparam logic [CNT_W-1:0] COMMIT_W = CNT_W'(COMMIT_BYTES);

   logic committed;

   assign committed = sending && !retain && (tx_bytes >= COMMIT_W);

   always_ff @(posedge clk) begin
      if (!rst_n)         release_ptr <= '0;
      else if (end_evt)   release_ptr <= frame_end;
      else if (committed) release_ptr <= rd_ptr;
   end

   // R6
   early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sending && !retain && tx_bytes < COMMIT_W && !end_evt) |=> $stable(release_ptr));
   // R7
   retain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sending && retain && !end_evt) |=> $stable(release_ptr));
   // R8
   end_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_evt |=> (release_ptr == $past(frame_end)));

endmodule

// File: rtl/txf_gate.sv
module txf_gate #(
   parameter int DEPTH        = 512,
   parameter int CNT_W        = 16,
   parameter int COMMIT_BYTES = 64,
   parameter bit REG_REQ      = 1'b1,
   localparam int LVL_W       = $clog2(DEPTH + 1),
   localparam int PTR_W       = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [CNT_W-1:0] frame_bytes,
   input  logic             frame_loaded,
   input  logic [CNT_W-1:0] tx_bytes,
   input  logic [PTR_W-1:0] rd_ptr,
   input  logic [PTR_W-1:0] frame_end,
   input  logic             backoff_busy,
   input  logic             coll_retry,
   input  logic             tx_done,
   input  logic             tx_drop,
   input  logic [1:0]       cfg_wmark,
   input  logic [1:0]       cfg_start,
   input  logic             cfg_rex_retry,
   input  logic             cfg_rex_uflo,
   output logic             bus_req,
   output logic             tx_start,
   output logic             rewind,
   output logic [PTR_W-1:0] release_ptr
);

   if (DEPTH < 256) begin : g_depth_bad
      $error("txf_gate: DEPTH must hold the largest threshold (256)");
   end
   if (CNT_W < 9) begin : g_cnt_bad
      $error("txf_gate: CNT_W too narrow for the thresholds");
   end
   if (COMMIT_BYTES < 1 || COMMIT_BYTES >= (1 << CNT_W)) begin : g_commit_bad
      $error("txf_gate: COMMIT_BYTES out of range");
   end

   logic retain;
   logic end_evt;
   logic sending;

   assign retain  = cfg_rex_retry | cfg_rex_uflo;
   assign end_evt = tx_done | tx_drop;

   txf_refill #(.DEPTH(DEPTH), .LVL_W(LVL_W), .REG_OUT(REG_REQ)) u_refill (
      .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level),
      .cfg_wmark(cfg_wmark), .bus_req(bus_req)
   );

   txf_start #(.CNT_W(CNT_W)) u_start (
      .clk(clk), .rst_n(rst_n), .frame_bytes(frame_bytes),
      .frame_loaded(frame_loaded), .backoff_busy(backoff_busy),
      .coll_retry(coll_retry), .end_evt(end_evt), .cfg_start(cfg_start),
      .retain(retain), .tx_start(tx_start), .rewind(rewind), .sending(sending)
   );

   txf_release #(.CNT_W(CNT_W), .PTR_W(PTR_W), .COMMIT_BYTES(COMMIT_BYTES)) u_release (
      .clk(clk), .rst_n(rst_n), .sending(sending), .retain(retain),
      .tx_bytes(tx_bytes), .rd_ptr(rd_ptr), .frame_end(frame_end),
      .end_evt(end_evt), .release_ptr(release_ptr)
   );

endmodule

// File: tb/txf_gate_tb.sv
module txf_gate_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 512;
   localparam int CNT_W = 16;
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam int PTR_W = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LVL_W-1:0] fifo_level = '0;
   logic [CNT_W-1:0] frame_bytes = '0;
   logic frame_loaded = 1'b0;
   logic [CNT_W-1:0] tx_bytes = '0;
   logic [PTR_W-1:0] rd_ptr = '0;
   logic [PTR_W-1:0] frame_end = '0;
   logic backoff_busy = 1'b0, coll_retry = 1'b0, tx_done = 1'b0, tx_drop = 1'b0;
   logic [1:0] cfg_wmark = 2'b01, cfg_start = 2'b01;
   logic cfg_rex_retry = 1'b0, cfg_rex_uflo = 1'b0;
   logic bus_req, tx_start, rewind;
   logic [PTR_W-1:0] release_ptr;

   int total = 0, failed = 0;
   bit finished = 0;

   // reference model state
   int m_req = 0, m_start = 0, m_rew = 0, m_rel = 0, m_send = 0, m_pend = 0;

   txf_gate u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .frame_bytes(frame_bytes),
      .frame_loaded(frame_loaded), .tx_bytes(tx_bytes), .rd_ptr(rd_ptr),
      .frame_end(frame_end), .backoff_busy(backoff_busy), .coll_retry(coll_retry),
      .tx_done(tx_done), .tx_drop(tx_drop), .cfg_wmark(cfg_wmark),
      .cfg_start(cfg_start), .cfg_rex_retry(cfg_rex_retry), .cfg_rex_uflo(cfg_rex_uflo),
      .bus_req(bus_req), .tx_start(tx_start), .rewind(rewind), .release_ptr(release_ptr)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int code_bytes(input logic [1:0] c);
      int t[4] = '{16, 64, 128, 256};
      return t[c];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_req = 0; m_start = 0; m_rew = 0; m_rel = 0; m_send = 0; m_pend = 0;
      end else begin
         int keep;
         keep    = (cfg_rex_retry || cfg_rex_uflo) ? 1 : 0;
         m_req   = ((DEPTH - int'(fifo_level)) >= code_bytes(cfg_wmark)) ? 1 : 0;
         m_start = 0;
         m_rew   = 0;
         if (tx_done || tx_drop) m_rel = int'(frame_end);
         else if (m_send == 1 && keep == 0 && int'(tx_bytes) >= 64) m_rel = int'(rd_ptr);
         if (tx_done || tx_drop) begin
            m_send = 0; m_pend = 0;
         end else if (m_send == 0) begin
            int ok;
            ok = m_pend ? int'(frame_loaded)
                        : ((frame_loaded || int'(frame_bytes) >= code_bytes(cfg_start)) ? 1 : 0);
            if (ok != 0 && !backoff_busy) begin
               m_start = 1; m_send = 1; m_pend = 0;
            end
         end else if (coll_retry) begin
            m_rew = 1; m_send = 0; m_pend = keep;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         failed++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      check("R1 bus_req", int'(bus_req), m_req);
      check("R4 tx_start", int'(tx_start), m_start);
      check("R5 rewind", int'(rewind), m_rew);
      check("R6 release_ptr", int'(release_ptr), m_rel);
   endtask

   task automatic pulse_clear();
      coll_retry = 0; tx_done = 0; tx_drop = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         total++; failed++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset bus_req", int'(bus_req), 0);
      check("R10 reset tx_start", int'(tx_start), 0);
      check("R10 reset release_ptr", int'(release_ptr), 0);
      rst_n = 1;

      // R1 watermark boundaries
      fifo_level = LVL_W'(497); cfg_wmark = 2'b00; step();
      check("R1 free15 wm16", int'(bus_req), 0);
      fifo_level = LVL_W'(496); step();
      check("R1 free16 wm16", int'(bus_req), 1);
      cfg_wmark = 2'b11; fifo_level = LVL_W'(257); step();
      check("R1 free255 wm256", int'(bus_req), 0);
      fifo_level = LVL_W'(256); step();
      check("R1 free256 wm256", int'(bus_req), 1);
      cfg_wmark = 2'b10; fifo_level = LVL_W'(385); step();
      check("R1 free127 wm128", int'(bus_req), 0);

      // R2 threshold 64
      cfg_wmark = 2'b01; fifo_level = '0; frame_end = PTR_W'(100);
      frame_bytes = CNT_W'(63); step();
      check("R2 63 below 64", int'(tx_start), 0);
      frame_bytes = CNT_W'(64); step();
      check("R2 64 reaches 64", int'(tx_start), 1);
      step();
      check("R4 pulse one cycle", int'(tx_start), 0);

      // R6 hold before commit
      tx_bytes = CNT_W'(40); rd_ptr = PTR_W'(30); step();
      check("R6 hold before 64", int'(release_ptr), 0);
      // R5 collision rewind
      coll_retry = 1; step(); pulse_clear();
      check("R5 rewind pulse", int'(rewind), 1);
      backoff_busy = 1; tx_bytes = '0; rd_ptr = '0;
      repeat (3) step();
      check("R4 backoff suppresses", int'(tx_start), 0);
      backoff_busy = 0; step();
      check("R4 restart after backoff", int'(tx_start), 1);
      tx_bytes = CNT_W'(70); rd_ptr = PTR_W'(60); step();
      check("R6 follows rd_ptr", int'(release_ptr), 60);
      rd_ptr = PTR_W'(75); step();
      check("R6 tracks rd_ptr", int'(release_ptr), 75);
      tx_done = 1; frame_bytes = '0; step(); pulse_clear();
      check("R8 done loads end", int'(release_ptr), 100);

      // R3 short frame override, threshold 128
      cfg_start = 2'b10; tx_bytes = '0; frame_bytes = CNT_W'(30); step();
      check("R2 30 below 128", int'(tx_start), 0);
      frame_loaded = 1; frame_end = PTR_W'(130); step();
      check("R3 loaded overrides", int'(tx_start), 1);
      tx_done = 1; frame_loaded = 0; frame_bytes = '0; step(); pulse_clear();
      check("R8 done end 130", int'(release_ptr), 130);

      // R7 and R9 retain mode
      cfg_start = 2'b01; cfg_rex_retry = 1; frame_end = PTR_W'(400);
      frame_bytes = CNT_W'(100); step();
      check("R2 retain start", int'(tx_start), 1);
      tx_bytes = CNT_W'(120); rd_ptr = PTR_W'(250); step(); step();
      check("R7 held in retain", int'(release_ptr), 130);
      coll_retry = 1; tx_bytes = '0; step(); pulse_clear();
      check("R5 retain rewind", int'(rewind), 1);
      frame_bytes = CNT_W'(200); step(); step();
      check("R9 waits for loaded", int'(tx_start), 0);
      frame_loaded = 1; step();
      check("R9 starts when loaded", int'(tx_start), 1);
      cfg_rex_retry = 0; cfg_rex_uflo = 1; tx_bytes = CNT_W'(300); rd_ptr = PTR_W'(300); step();
      check("R7 held in underflow mode", int'(release_ptr), 130);
      tx_drop = 1; frame_loaded = 0; frame_bytes = '0; step(); pulse_clear();
      check("R8 drop loads end", int'(release_ptr), 400);
      cfg_rex_uflo = 0; tx_bytes = '0;

      // mixed stimulus against the model
      for (int i = 0; i < 600; i++) begin
         fifo_level    = LVL_W'($urandom_range(0, DEPTH));
         frame_bytes   = CNT_W'($urandom_range(0, 300));
         frame_loaded  = ($urandom_range(0, 3) == 0);
         tx_bytes      = CNT_W'($urandom_range(0, 120));
         rd_ptr        = PTR_W'($urandom);
         frame_end     = PTR_W'($urandom);
         backoff_busy  = ($urandom_range(0, 2) == 0);
         coll_retry    = ($urandom_range(0, 5) == 0);
         tx_done       = ($urandom_range(0, 9) == 0);
         tx_drop       = ($urandom_range(0, 19) == 0);
         cfg_wmark     = 2'($urandom);
         cfg_start     = 2'($urandom);
         cfg_rex_retry = ($urandom_range(0, 3) == 0);
         cfg_rex_uflo  = ($urandom_range(0, 5) == 0);
         step();
      end

      // R10 reset in mid-run
      rst_n = 0; pulse_clear(); step();
      check("R10 reset again tx_start", int'(tx_start), 0);
      check("R10 reset again release", int'(release_ptr), 0);

      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule